// File: doc/BRIEF.md
# Flash Command Interrupt Aggregator

This block gathers event pulses from a multi-thread flash command engine and error detectors and turns them into one level-sensitive interrupt line toward the host. Software reaches it over a small register bus. Through that bus it sets a master enable and a mask bit for each error source, and it reads and clears sticky status flags by writing ones to them. It can also select one command thread and read back the status that thread's last command left behind.

Error and event sources latch their status bit whether they are masked or not. Unmasking a source therefore exposes any event that is still pending. Command completions set a per-thread flag only when the finishing command asked for an interrupt. The extended status record (done, fail, error index) is captured on every completion. The interrupt line is registered and stays high until software clears every flag that contributes to it.

Register map (12-bit byte address, 32-bit data):
- 0x010: thread select, bits [2:0].
- 0x014: selected thread record, read-only. Bit 0 is done, bits [4:1] are the error index, bit 5 is fail, and the other bits read 0.
- 0x110: source status, one bit per source in bits [7:0], write-one-to-clear.
- 0x114: enables. Bit 31 is the master enable and bits [7:0] are the per-source enables.
- 0x138: thread completion flags, one bit per thread in bits [7:0], write-one-to-clear.

Top module: `irq_aggregator`

## Requirements
- R1: After reset every register reads 0 (thread select, enables, source status, completion flags and all thread records), and irq_out is 0.
- R2: While the master enable (0x114 bit 31) is 0, irq_out stays 0 whatever the flags hold.
- R3: With the master enable set, a pending source status bit i drives irq_out only if enable bit i of 0x114 is 1. Each source is masked independently of the others.
- R4: A pulse on src_evt[i] sets status bit i of 0x110 whether or not that source is enabled.
- R5: Writing 0x110 or 0x138 clears the bits written as 1 and leaves the bits written as 0 unchanged.
- R6: irq_out is high while any enabled source flag or any completion flag is set under the master enable. It drops only after all of them are cleared.
- R7: Writing 0x114 never changes the status in 0x110. A source that was pending before it was enabled raises irq_out once enabled.
- R8: A completion (cmp_valid) on thread t sets bit t of 0x138 only when cmp_irq_req is 1.
- R9: Completion flags have no per-thread mask. Any set flag raises irq_out when the master enable is 1.
- R10: Reading 0x014 returns the record captured at the last completion of the thread named by 0x010, whether or not that completion requested an interrupt.
- R11: When a hardware set and a software clear hit the same status or completion bit in one cycle, the bit ends up set.
- R12: irq_out changes on the clock edge after the edge that updates the flags or enables that cause the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 12 | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| src_evt | input | 8 | One-cycle event pulses, one per error source |
| cmp_valid | input | 1 | A command finished on thread cmp_thread |
| cmp_thread | input | 3 | Thread number of the finishing command |
| cmp_irq_req | input | 1 | The finishing command asked for an interrupt |
| cmp_fail | input | 1 | The finishing command failed |
| cmp_err_idx | input | 4 | Index of the first failing operation |
| irq_out | output | 1 | Level interrupt to the host |

## Verification
The mask path is swept exhaustively. For every pairing of the single enabled source and the pulsed source, the bench checks that the status latches the pulse while irq_out follows only the matching pair, which separates latch-regardless behaviour from masking. Every thread is completed once with and once without an interrupt request. Each thread gets a distinct fail/index pattern, and the records are read back through the pointer, so a wrong index or a wrong gate shows up as a mismatched thread. Further targeted sequences cover several cases: partial clears of multiple pending flags, stale events exposed by a late enable, the master enable switched off, and clears issued in the same cycle as new events. These sequences tell level behaviour, register latency and set-over-clear priority apart from a design that merely pulses.

// File: rtl/irqa_pkg.sv
// Package: shared register offsets and the per-thread status record.
// Assumes a 12-bit byte address bus; offsets are fixed by the host driver.
package irqa_pkg;
    localparam int ADDR_W    = 12;
    localparam int DATA_W    = 32;
    localparam int ERR_IDX_W = 4;

    localparam logic [ADDR_W-1:0] OFS_THR_SEL  = 12'h010;
    localparam logic [ADDR_W-1:0] OFS_THR_REC  = 12'h014;
    localparam logic [ADDR_W-1:0] OFS_SRC_STAT = 12'h110;
    localparam logic [ADDR_W-1:0] OFS_ENABLE   = 12'h114;
    localparam logic [ADDR_W-1:0] OFS_CMP_STAT = 12'h138;

    localparam int MASTER_EN_BIT = 31;

    // Record captured when a command finishes: bit0 done, [4:1] index, bit5 fail.
    typedef struct packed {
        logic                 fail;
        logic [ERR_IDX_W-1:0] err_idx;
        logic                 done;
    } thr_rec_t;

    localparam int REC_W = $bits(thr_rec_t);
endpackage

// File: rtl/irqa_src_bank.sv
// Module: per-source sticky status with independent enable bits.
// Status latches events regardless of enable; write-one clears; set beats clear.
// Assumes event pulses are already synchronous to clk.
module irqa_src_bank #(
    parameter int NUM_SRC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt,
    input  logic               clr_we,
    input  logic [NUM_SRC-1:0] clr_mask,
    input  logic               en_we,
    input  logic [NUM_SRC-1:0] en_wdata,
    output logic [NUM_SRC-1:0] stat,
    output logic [NUM_SRC-1:0] en,
    output logic               pend
);
    logic [NUM_SRC-1:0] stat_q;
    logic [NUM_SRC-1:0] en_q;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
        // Sticky status bit: event set has priority over software clear.
        always_ff @(posedge clk) begin
            if (!rst_n)
                stat_q[i] <= 1'b0;
            else if (evt[i])
                stat_q[i] <= 1'b1;
            else if (clr_we && clr_mask[i])
                stat_q[i] <= 1'b0;
        end

        // Per-source enable bit, written as a whole with the enable register.
        always_ff @(posedge clk) begin
            if (!rst_n)
                en_q[i] <= 1'b0;
            else if (en_we)
                en_q[i] <= en_wdata[i];
        end
    end

    assign stat = stat_q;
    assign en   = en_q;
    assign pend = |(stat_q & en_q);
endmodule

// File: rtl/irqa_thread_bank.sv
// Module: per-thread completion flags and last-command status records.
// A flag sets only for commands that requested an interrupt; the record is
// captured on every completion. Set beats a same-cycle software clear.
module irqa_thread_bank #(
    parameter int NUM_THR = 8,
    localparam int THR_W  = (NUM_THR > 1) ? $clog2(NUM_THR) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmp_valid,
    input  logic [THR_W-1:0]     cmp_thread,
    input  logic                 cmp_irq_req,
    input  irqa_pkg::thr_rec_t   cmp_rec,
    input  logic                 clr_we,
    input  logic [NUM_THR-1:0]   clr_mask,
    input  logic [THR_W-1:0]     sel,
    output logic [NUM_THR-1:0]   flags,
    output irqa_pkg::thr_rec_t   sel_rec,
    output logic                 pend
);
    logic [NUM_THR-1:0]  flag_q;
    irqa_pkg::thr_rec_t  rec_q [NUM_THR];

    for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
        logic hit;
        assign hit = cmp_valid && (cmp_thread == THR_W'(t));

        // Completion flag: requested completion sets, write-one clears.
        always_ff @(posedge clk) begin
            if (!rst_n)
                flag_q[t] <= 1'b0;
            else if (hit && cmp_irq_req)
                flag_q[t] <= 1'b1;
            else if (clr_we && clr_mask[t])
                flag_q[t] <= 1'b0;
        end

        // Status record: refreshed on every completion of this thread.
        always_ff @(posedge clk) begin
            if (!rst_n)
                rec_q[t] <= '0;
            else if (hit)
                rec_q[t] <= cmp_rec;
        end
    end

    // Pointer-selected record; out-of-range pointers read as zero.
    always_comb begin
        sel_rec = '0;
        for (int t = 0; t < NUM_THR; t++)
            if (sel == THR_W'(t))
                sel_rec = rec_q[t];
    end

    assign flags = flag_q;
    assign pend  = |flag_q;
endmodule

// File: rtl/irqa_regif.sv
// Module: host register decode, master enable, thread pointer, read mux.
// Assumes single-cycle write strobes; reads are combinational from address.
module irqa_regif #(
    parameter int NUM_SRC = 8,
    parameter int NUM_THR = 8,
    localparam int THR_W  = (NUM_THR > 1) ? $clog2(NUM_THR) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         bus_wr,
    input  logic [irqa_pkg::ADDR_W-1:0]  bus_addr,
    input  logic [irqa_pkg::DATA_W-1:0]  bus_wdata,
    output logic [irqa_pkg::DATA_W-1:0]  bus_rdata,
    output logic                         src_clr_we,
    output logic                         en_we,
    output logic                         cmp_clr_we,
    output logic                         master_en,
    output logic [THR_W-1:0]             sel,
    input  logic [NUM_SRC-1:0]           src_stat,
    input  logic [NUM_SRC-1:0]           src_en,
    input  logic [NUM_THR-1:0]           cmp_flags,
    input  irqa_pkg::thr_rec_t           sel_rec
);
    import irqa_pkg::*;

    logic            sel_we;
    logic            master_q;
    logic [THR_W-1:0] sel_q;
    logic            unused_wdata;

    // Write strobe decode.
    always_comb begin
        sel_we     = bus_wr && (bus_addr == OFS_THR_SEL);
        en_we      = bus_wr && (bus_addr == OFS_ENABLE);
        src_clr_we = bus_wr && (bus_addr == OFS_SRC_STAT);
        cmp_clr_we = bus_wr && (bus_addr == OFS_CMP_STAT);
    end

    // Master enable bit of the enable register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            master_q <= 1'b0;
        else if (en_we)
            master_q <= bus_wdata[MASTER_EN_BIT];
    end

    // Thread select pointer.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel_q <= '0;
        else if (sel_we)
            sel_q <= bus_wdata[THR_W-1:0];
    end

    // Read data mux; unmapped addresses read as zero.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_THR_SEL:  bus_rdata[THR_W-1:0]   = sel_q;
            OFS_THR_REC:  bus_rdata[REC_W-1:0]   = sel_rec;
            OFS_SRC_STAT: bus_rdata[NUM_SRC-1:0] = src_stat;
            OFS_ENABLE: begin
                bus_rdata[NUM_SRC-1:0]     = src_en;
                bus_rdata[MASTER_EN_BIT]   = master_q;
            end
            OFS_CMP_STAT: bus_rdata[NUM_THR-1:0] = cmp_flags;
            default:      bus_rdata = '0;
        endcase
    end

    assign unused_wdata = ^bus_wdata;
    assign master_en    = master_q;
    assign sel          = sel_q;
endmodule

// File: rtl/irq_aggregator.sv
// Module: top of the interrupt aggregator.
// Combines source and thread flags under the master enable into a registered
// level interrupt. Assumes NUM_SRC <= 31 so sources do not overlap bit 31.
module irq_aggregator #(
    parameter int NUM_SRC = 8,
    parameter int NUM_THR = 8,
    localparam int THR_W  = (NUM_THR > 1) ? $clog2(NUM_THR) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         bus_wr,
    input  logic [irqa_pkg::ADDR_W-1:0]  bus_addr,
    input  logic [irqa_pkg::DATA_W-1:0]  bus_wdata,
    output logic [irqa_pkg::DATA_W-1:0]  bus_rdata,
    input  logic [NUM_SRC-1:0]           src_evt,
    input  logic                         cmp_valid,
    input  logic [THR_W-1:0]             cmp_thread,
    input  logic                         cmp_irq_req,
    input  logic                         cmp_fail,
    input  logic [irqa_pkg::ERR_IDX_W-1:0] cmp_err_idx,
    output logic                         irq_out
);
    import irqa_pkg::*;

    logic               src_clr_we, en_we, cmp_clr_we;
    logic               glob_en;
    logic [THR_W-1:0]   sel;
    logic [NUM_SRC-1:0] src_stat, src_en;
    logic [NUM_THR-1:0] cmp_flags;
    logic               src_pend, cmp_pend;
    thr_rec_t           sel_rec, cmp_rec;
    logic               irq_q;

    assign cmp_rec = '{fail: cmp_fail, err_idx: cmp_err_idx, done: 1'b1};

    irqa_regif #(.NUM_SRC(NUM_SRC), .NUM_THR(NUM_THR)) u_regif (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .src_clr_we(src_clr_we), .en_we(en_we), .cmp_clr_we(cmp_clr_we),
        .master_en(glob_en), .sel(sel),
        .src_stat(src_stat), .src_en(src_en),
        .cmp_flags(cmp_flags), .sel_rec(sel_rec)
    );

    irqa_src_bank #(.NUM_SRC(NUM_SRC)) u_src (
        .clk(clk), .rst_n(rst_n),
        .evt(src_evt),
        .clr_we(src_clr_we), .clr_mask(bus_wdata[NUM_SRC-1:0]),
        .en_we(en_we), .en_wdata(bus_wdata[NUM_SRC-1:0]),
        .stat(src_stat), .en(src_en), .pend(src_pend)
    );

    irqa_thread_bank #(.NUM_THR(NUM_THR)) u_thr (
        .clk(clk), .rst_n(rst_n),
        .cmp_valid(cmp_valid), .cmp_thread(cmp_thread),
        .cmp_irq_req(cmp_irq_req), .cmp_rec(cmp_rec),
        .clr_we(cmp_clr_we), .clr_mask(bus_wdata[NUM_THR-1:0]),
        .sel(sel),
        .flags(cmp_flags), .sel_rec(sel_rec), .pend(cmp_pend)
    );

    // Registered interrupt level: master enable gates both flag groups.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_q <= 1'b0;
        else
            irq_q <= glob_en && (src_pend || cmp_pend);
    end

    assign irq_out = irq_q;
endmodule

// File: rtl/irq_aggregator_chk.sv
// Checker: temporal properties of the aggregator, bound into the top module.
module irq_aggregator_chk #(
    parameter int NUM_SRC = 8,
    parameter int NUM_THR = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               irq_out,
    input logic               glob_en,
    input logic [NUM_SRC-1:0] src_evt,
    input logic [NUM_SRC-1:0] src_stat,
    input logic               cmp_valid,
    input logic               cmp_irq_req,
    input logic [NUM_THR-1:0] cmp_flags
);
    // R1
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> (!irq_out && src_stat == '0 && cmp_flags == '0));

    // R2
    master_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !glob_en |=> !irq_out);

    // R4
    evt_latches_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_evt != '0) |=> ((src_stat & $past(src_evt)) == $past(src_evt)));

    // R5
    stat_rise_needs_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_evt == '0) |=> ((src_stat & ~$past(src_stat)) == '0));

    // R8
    cmp_rise_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmp_valid || !cmp_irq_req) |=> ((cmp_flags & ~$past(cmp_flags)) == '0));

    // R9
    cmp_drives_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (glob_en && cmp_flags != '0) |=> irq_out);

    // R6
    irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_stat == '0 && cmp_flags == '0) |=> !irq_out);
endmodule

bind irq_aggregator irq_aggregator_chk #(.NUM_SRC(NUM_SRC), .NUM_THR(NUM_THR)) u_chk (
    .clk(clk), .rst_n(rst_n), .irq_out(irq_out), .glob_en(glob_en),
    .src_evt(src_evt), .src_stat(src_stat),
    .cmp_valid(cmp_valid), .cmp_irq_req(cmp_irq_req), .cmp_flags(cmp_flags)
);

// File: tb/irq_aggregator_test.sv
// Bench: sweeps masks, threads and collisions; expected values computed here.
module irq_aggregator_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [11:0] A_SEL = 12'h010, A_REC = 12'h014,
                            A_STAT = 12'h110, A_EN = 12'h114, A_CMP = 12'h138;
    localparam logic [31:0] MASTER = 32'h8000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  src_evt = '0;
    logic        cmp_valid = 1'b0;
    logic [2:0]  cmp_thread = '0;
    logic        cmp_irq_req = 1'b0;
    logic        cmp_fail = 1'b0;
    logic [3:0]  cmp_err_idx = '0;
    logic        irq_out;

    int total = 0;
    int bad = 0;
    logic [7:0] exp_rec [8];

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_aggregator uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_evt(src_evt),
        .cmp_valid(cmp_valid), .cmp_thread(cmp_thread),
        .cmp_irq_req(cmp_irq_req), .cmp_fail(cmp_fail),
        .cmp_err_idx(cmp_err_idx), .irq_out(irq_out)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp_v);
        total++;
        if (act !== exp_v) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp_v);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        tick();
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic pulse(input logic [7:0] m);
        src_evt = m;
        tick();
        src_evt = '0;
    endtask

    task automatic complete(input int t, input logic req, input logic f, input logic [3:0] idx);
        cmp_valid = 1'b1; cmp_thread = 3'(t); cmp_irq_req = req;
        cmp_fail = f; cmp_err_idx = idx;
        tick();
        cmp_valid = 1'b0; cmp_irq_req = 1'b0;
        exp_rec[t] = {2'b00, f, idx, 1'b1};
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        for (int t = 0; t < 8; t++) exp_rec[t] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 irq", {31'b0, irq_out}, 0);
        rd(A_SEL, d);  check("R1 sel", d, 0);
        rd(A_EN, d);   check("R1 en", d, 0);
        rd(A_STAT, d); check("R1 stat", d, 0);
        rd(A_CMP, d);  check("R1 cmp", d, 0);
        rd(A_REC, d);  check("R1 rec", d, 0);

        // R3/R4 exhaustive: one enabled source against each pulsed source
        for (int i = 0; i < 8; i++) begin
            wr(A_EN, MASTER | (32'd1 << i));
            for (int j = 0; j < 8; j++) begin
                wr(A_STAT, 32'hFF);
                tick();
                pulse(8'(1 << j));
                tick();
                check($sformatf("R3 irq en=%0d evt=%0d", i, j), {31'b0, irq_out}, {31'b0, i == j});
                rd(A_STAT, d);
                check($sformatf("R4 stat en=%0d evt=%0d", i, j), d, 32'd1 << j);
            end
        end
        wr(A_STAT, 32'hFF);

        // R2 master off with all sources enabled and pending
        wr(A_EN, 32'h0000_00FF);
        pulse(8'hFF);
        tick(); tick();
        check("R2 master off irq", {31'b0, irq_out}, 0);
        rd(A_EN, d); check("R2 enable readback", d, 32'hFF);

        // R5 partial clear, zeros keep bits
        wr(A_STAT, 32'h0F);
        rd(A_STAT, d); check("R5 w1c partial", d, 32'hF0);
        wr(A_STAT, 32'h00);
        rd(A_STAT, d); check("R5 write zero", d, 32'hF0);
        wr(A_STAT, 32'hFF);

        // R6/R12 level held until last enabled flag cleared, one-cycle latency
        wr(A_EN, MASTER | 32'h3);
        pulse(8'h03);
        check("R12 irq before next edge", {31'b0, irq_out}, 0);
        tick();
        check("R12 irq one edge later", {31'b0, irq_out}, 1);
        wr(A_STAT, 32'h01);
        tick();
        check("R6 held with one flag left", {31'b0, irq_out}, 1);
        wr(A_STAT, 32'h02);
        check("R12 still high right after clear", {31'b0, irq_out}, 1);
        tick();
        check("R6 drops after all cleared", {31'b0, irq_out}, 0);

        // R7 stale event exposed by late enable
        wr(A_EN, MASTER);
        pulse(8'h10);
        tick();
        check("R7 masked pending irq", {31'b0, irq_out}, 0);
        wr(A_EN, MASTER | 32'h10);
        rd(A_STAT, d); check("R7 enable keeps status", d, 32'h10);
        tick();
        check("R7 stale raises irq", {31'b0, irq_out}, 1);
        wr(A_STAT, 32'hFF);
        wr(A_EN, MASTER);
        tick();

        // R8/R9/R10 each thread with and without request
        for (int t = 0; t < 8; t++) begin
            complete(t, 1'b0, t[0], 4'(t + 3));
            tick();
            rd(A_CMP, d); check($sformatf("R8 no req t=%0d", t), d, 0);
            check($sformatf("R9 no req irq t=%0d", t), {31'b0, irq_out}, 0);
            complete(t, 1'b1, ~t[0], 4'(15 - t));
            rd(A_CMP, d); check($sformatf("R8 req t=%0d", t), d, 32'd1 << t);
            tick();
            check($sformatf("R9 irq t=%0d", t), {31'b0, irq_out}, 1);
            wr(A_CMP, 32'd1 << t);
            tick();
        end
        for (int t = 0; t < 8; t++) complete(t, 1'b0, t[1], 4'(t * 2));
        for (int t = 7; t >= 0; t--) begin
            wr(A_SEL, 32'(t));
            rd(A_REC, d); check($sformatf("R10 rec t=%0d", t), d, {24'b0, exp_rec[t]});
        end

        // R9 master off masks completion flags
        complete(5, 1'b1, 1'b0, 4'd0);
        wr(A_EN, 32'h0);
        tick();
        check("R9 master off cmp", {31'b0, irq_out}, 0);
        wr(A_CMP, 32'hFF);

        // R11 set beats same-cycle clear
        bus_wr = 1'b1; bus_addr = A_STAT; bus_wdata = 32'hFF; src_evt = 8'h40;
        tick();
        bus_wr = 1'b0; src_evt = '0;
        rd(A_STAT, d); check("R11 source collision", d, 32'h40);
        complete(2, 1'b1, 1'b0, 4'd1);
        bus_wr = 1'b1; bus_addr = A_CMP; bus_wdata = 32'h04;
        cmp_valid = 1'b1; cmp_thread = 3'd2; cmp_irq_req = 1'b1;
        tick();
        bus_wr = 1'b0; cmp_valid = 1'b0; cmp_irq_req = 1'b0;
        rd(A_CMP, d); check("R11 thread collision", d, 32'h04);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule